// File: doc/BRIEF.md
# Dual-Mode Carrier Loop Filter

This block turns the two error measurements of a carrier recovery loop, a phase error and a frequency error, into the frequency-control word of a numerically controlled oscillator. Out of reset it runs in joint acquisition. In that mode a proportional-integral frequency path and a third-order phase path are updated together, and their outputs are summed into the word. The phase path has two cascaded integrators and three gains. Once the frequency error magnitude is within a programmed capture limit, the block drops the frequency path. It hands the frequency path's integrated offset over to the phase path and continues in phase-only tracking. Tracking lasts until the phase error stays above a programmed slip limit for a programmed number of consecutive updates. The block then treats the loop as unlocked and goes back to joint acquisition.

The filter advances only on updates that carry a valid strobe. Every gain is a right shift. All integrators, and the output word, clamp at the limits of their signed range.

Top module: `fpll_loop_filter`

## Requirements
- R1: While reset is asserted and right after it, `nco_word` is 0 and `track_mode` is 0 (acquisition); all integrators start from 0.
- R2: On a cycle with `err_vld` low, `nco_word` and `track_mode` keep their values whatever the error inputs do.
- R3: On a valid update in acquisition, the word registered at that clock edge is computed as follows. First the phase integrators update: I2 = sat(I2 + (pe>>>C)), then I1 = sat(I1 + (pe>>>B) + I2). The frequency integrator updates: F = sat(F + (fe>>>KI)). The word is sat((pe>>>A) + I1 + (fe>>>KP) + F).
- R4: On a valid update in tracking, I1 and I2 update as in R3 and the word is sat((pe>>>A) + I1). `freq_err` has no effect.
- R5: A valid update in acquisition with |fe| <= `capture_lim` sets `track_mode` to 1 at that edge, and the word of that update still follows R3. The new F is then added into I1 with saturation, and F is cleared. An update with |fe| above the limit leaves the mode in acquisition.
- R6: In tracking, a valid update with |pe| > `slip_lim` advances a slip count, and a valid update with |pe| <= `slip_lim` clears it. Cycles without `err_vld` leave the count unchanged. When the count reaches max(`slip_len`,1), `track_mode` returns to 0 at that edge and the count restarts.
- R7: Each integrator and the output word saturate at the largest positive and the most negative AW-bit two's-complement value; they never wrap.
- R8: I1 and I2 survive both mode changes. F restarts from 0 on every return to acquisition.
- R9: Every gain is an arithmetic right shift of the sign-extended error by its shift input (0..31), rounding toward minus infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_vld | input | 1 | Error inputs carry a new measurement this cycle |
| phase_err | input | EW | Signed phase discriminator output |
| freq_err | input | EW | Signed frequency discriminator output |
| capture_lim | input | EW | Unsigned \|fe\| limit for entering tracking |
| slip_lim | input | EW | Unsigned \|pe\| limit above which an update counts as a slip |
| slip_len | input | CNTW | Consecutive slips that declare loss of lock |
| fll_kp_sh | input | SHW | Frequency path proportional shift |
| fll_ki_sh | input | SHW | Frequency path integral shift |
| pll_a_sh | input | SHW | Phase path proportional shift (A) |
| pll_b_sh | input | SHW | Phase path first-integrator shift (B) |
| pll_c_sh | input | SHW | Phase path second-integrator shift (C) |
| nco_word | output | AW | Signed oscillator frequency-control word |
| track_mode | output | 1 | 1 in phase-only tracking, 0 in joint acquisition |

## Verification
The bench looks at the capture boundary from both sides: a frequency error one count above the limit must not switch modes, and one exactly at it must. A design that used the wrong comparison would lock one update early or one update late. On the slip counter, a phase error exactly equal to the limit must clear the run, and idle cycles inside a run must not clear it. A design that got this wrong would leave tracking too soon or too late. The first tracking words must carry the handed-over frequency offset, so a design that dropped the frequency integrator at the switch would show a step in the word. Finally, a long run at full-scale phase error drives the integrators into their clamp, where a wrapping design would flip the word's sign.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
    typedef enum logic {
        MODE_ACQ = 1'b0,
        MODE_TRK = 1'b1
    } loop_mode_e;
endpackage

// File: rtl/lf_fll_path.sv
module lf_fll_path #(
    parameter int EW  = 16,
    parameter int AW  = 32,
    parameter int SHW = 5
) (
    input  logic signed [EW-1:0]  freq_err,
    input  logic        [SHW-1:0] kp_sh,
    input  logic        [SHW-1:0] ki_sh,
    input  logic signed [AW-1:0]  fint_q,
    output logic signed [AW-1:0]  prop_o,
    output logic signed [AW-1:0]  fint_n
);
    localparam int XW = AW + 2;
    localparam logic signed [XW-1:0] MAXV = {3'b000, {(AW-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {3'b111, {(AW-1){1'b0}}};

    function automatic logic signed [AW-1:0] clamp(input logic signed [XW-1:0] v);
        if (v > MAXV)      return MAXV[AW-1:0];
        else if (v < MINV) return MINV[AW-1:0];
        else               return v[AW-1:0];
    endfunction

    logic signed [XW-1:0] fe_x;
    logic signed [XW-1:0] fint_x;

    always_comb begin
        fe_x   = {{(XW-EW){freq_err[EW-1]}}, freq_err};
        fint_x = {{2{fint_q[AW-1]}}, fint_q};
        prop_o = clamp(fe_x >>> kp_sh);
        fint_n = clamp(fint_x + (fe_x >>> ki_sh));
    end
endmodule

// File: rtl/lf_pll_path.sv
module lf_pll_path #(
    parameter int EW  = 16,
    parameter int AW  = 32,
    parameter int SHW = 5
) (
    input  logic signed [EW-1:0]  phase_err,
    input  logic        [SHW-1:0] a_sh,
    input  logic        [SHW-1:0] b_sh,
    input  logic        [SHW-1:0] c_sh,
    input  logic signed [AW-1:0]  acc1_q,
    input  logic signed [AW-1:0]  acc2_q,
    output logic signed [AW-1:0]  prop_o,
    output logic signed [AW-1:0]  acc1_n,
    output logic signed [AW-1:0]  acc2_n
);
    localparam int XW = AW + 2;
    localparam logic signed [XW-1:0] MAXV = {3'b000, {(AW-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {3'b111, {(AW-1){1'b0}}};

    function automatic logic signed [AW-1:0] clamp(input logic signed [XW-1:0] v);
        if (v > MAXV)      return MAXV[AW-1:0];
        else if (v < MINV) return MINV[AW-1:0];
        else               return v[AW-1:0];
    endfunction

    function automatic logic signed [XW-1:0] wide(input logic signed [AW-1:0] v);
        return {{2{v[AW-1]}}, v};
    endfunction

    logic signed [XW-1:0] pe_x;

    always_comb begin
        pe_x   = {{(XW-EW){phase_err[EW-1]}}, phase_err};
        prop_o = clamp(pe_x >>> a_sh);
        acc2_n = clamp(wide(acc2_q) + (pe_x >>> c_sh));
        acc1_n = clamp(wide(acc1_q) + (pe_x >>> b_sh) + wide(acc2_n));
    end
endmodule

// File: rtl/lf_mode_ctrl.sv
module lf_mode_ctrl
    import fpll_pkg::*;
#(
    parameter int EW   = 16,
    parameter int CNTW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_vld,
    input  logic signed [EW-1:0] phase_err,
    input  logic signed [EW-1:0] freq_err,
    input  logic [EW-1:0]        capture_lim,
    input  logic [EW-1:0]        slip_lim,
    input  logic [CNTW-1:0]      slip_len,
    output loop_mode_e           mode_o,
    output logic                 go_track,
    output logic                 go_acq
);
    localparam int MW = EW + 1;
    localparam int CW = CNTW + 1;

    typedef struct packed {
        loop_mode_e      mode;
        logic [CNTW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic logic [MW-1:0] mag(input logic signed [EW-1:0] v);
        logic signed [MW-1:0] e;
        e = {v[EW-1], v};
        return e[MW-1] ? MW'(-e) : MW'(e);
    endfunction

    logic [CW-1:0] run_next;

    always_comb begin
        st_d     = st_q;
        go_track = 1'b0;
        go_acq   = 1'b0;
        run_next = CW'(st_q.cnt) + CW'(1);
        if (err_vld) begin
            case (st_q.mode)
                MODE_ACQ: begin
                    if (mag(freq_err) <= {1'b0, capture_lim}) begin
                        st_d.mode = MODE_TRK;
                        st_d.cnt  = '0;
                        go_track  = 1'b1;
                    end
                end
                MODE_TRK: begin
                    if (mag(phase_err) > {1'b0, slip_lim}) begin
                        if (run_next >= {1'b0, slip_len}) begin
                            st_d.mode = MODE_ACQ;
                            st_d.cnt  = '0;
                            go_acq    = 1'b1;
                        end else begin
                            st_d.cnt = run_next[CNTW-1:0];
                        end
                    end else begin
                        st_d.cnt = '0;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= MODE_ACQ;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
endmodule

// File: rtl/fpll_loop_filter.sv
module fpll_loop_filter
    import fpll_pkg::*;
#(
    parameter int EW   = 16,
    parameter int AW   = 32,
    parameter int SHW  = 5,
    parameter int CNTW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_vld,
    input  logic signed [EW-1:0] phase_err,
    input  logic signed [EW-1:0] freq_err,
    input  logic [EW-1:0]        capture_lim,
    input  logic [EW-1:0]        slip_lim,
    input  logic [CNTW-1:0]      slip_len,
    input  logic [SHW-1:0]       fll_kp_sh,
    input  logic [SHW-1:0]       fll_ki_sh,
    input  logic [SHW-1:0]       pll_a_sh,
    input  logic [SHW-1:0]       pll_b_sh,
    input  logic [SHW-1:0]       pll_c_sh,
    output logic signed [AW-1:0] nco_word,
    output logic                 track_mode
);
    localparam int XW = AW + 2;
    localparam logic signed [XW-1:0] MAXV = {3'b000, {(AW-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {3'b111, {(AW-1){1'b0}}};

    function automatic logic signed [AW-1:0] clamp(input logic signed [XW-1:0] v);
        if (v > MAXV)      return MAXV[AW-1:0];
        else if (v < MINV) return MINV[AW-1:0];
        else               return v[AW-1:0];
    endfunction

    function automatic logic signed [XW-1:0] wide(input logic signed [AW-1:0] v);
        return {{2{v[AW-1]}}, v};
    endfunction

    typedef struct packed {
        logic signed [AW-1:0] acc1;
        logic signed [AW-1:0] acc2;
        logic signed [AW-1:0] fint;
        logic signed [AW-1:0] word;
    } filt_t;

    filt_t st_d, st_q;

    loop_mode_e           mode_q;
    logic                 go_track, go_acq;
    logic signed [AW-1:0] pll_prop, acc1_n, acc2_n;
    logic signed [AW-1:0] fll_prop, fint_n;
    logic signed [XW-1:0] sum;

    lf_mode_ctrl #(.EW(EW), .CNTW(CNTW)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_vld    (err_vld),
        .phase_err  (phase_err),
        .freq_err   (freq_err),
        .capture_lim(capture_lim),
        .slip_lim   (slip_lim),
        .slip_len   (slip_len),
        .mode_o     (mode_q),
        .go_track   (go_track),
        .go_acq     (go_acq)
    );

    lf_pll_path #(.EW(EW), .AW(AW), .SHW(SHW)) u_pll (
        .phase_err(phase_err),
        .a_sh     (pll_a_sh),
        .b_sh     (pll_b_sh),
        .c_sh     (pll_c_sh),
        .acc1_q   (st_q.acc1),
        .acc2_q   (st_q.acc2),
        .prop_o   (pll_prop),
        .acc1_n   (acc1_n),
        .acc2_n   (acc2_n)
    );

    lf_fll_path #(.EW(EW), .AW(AW), .SHW(SHW)) u_fll (
        .freq_err(freq_err),
        .kp_sh   (fll_kp_sh),
        .ki_sh   (fll_ki_sh),
        .fint_q  (st_q.fint),
        .prop_o  (fll_prop),
        .fint_n  (fint_n)
    );

    always_comb begin
        st_d = st_q;
        sum  = wide(pll_prop) + wide(acc1_n);
        if (err_vld) begin
            st_d.acc2 = acc2_n;
            st_d.acc1 = acc1_n;
            if (mode_q == MODE_ACQ) begin
                sum = wide(pll_prop) + wide(acc1_n) + wide(fll_prop) + wide(fint_n);
                if (go_track) begin
                    // hand the frequency offset to the phase path so the word does not step
                    st_d.acc1 = clamp(wide(acc1_n) + wide(fint_n));
                    st_d.fint = '0;
                end else begin
                    st_d.fint = fint_n;
                end
            end else begin
                st_d.fint = '0;
            end
            st_d.word = clamp(sum);
        end
        if (go_acq) st_d.fint = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nco_word   = st_q.word;
    assign track_mode = (mode_q == MODE_TRK);
endmodule

// File: rtl/fpll_loop_filter_chk.sv
module fpll_loop_filter_chk #(
    parameter int EW   = 16,
    parameter int AW   = 32,
    parameter int SHW  = 5,
    parameter int CNTW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 err_vld,
    input logic signed [EW-1:0] phase_err,
    input logic signed [EW-1:0] freq_err,
    input logic [EW-1:0]        capture_lim,
    input logic [EW-1:0]        slip_lim,
    input logic [CNTW-1:0]      slip_len,
    input logic [SHW-1:0]       fll_kp_sh,
    input logic [SHW-1:0]       fll_ki_sh,
    input logic [SHW-1:0]       pll_a_sh,
    input logic [SHW-1:0]       pll_b_sh,
    input logic [SHW-1:0]       pll_c_sh,
    input logic signed [AW-1:0] nco_word,
    input logic                 track_mode
);
    logic [EW:0] fe_abs, pe_abs;
    assign fe_abs = freq_err[EW-1]  ? (EW+1)'(-{freq_err[EW-1], freq_err})   : (EW+1)'({1'b0, freq_err});
    assign pe_abs = phase_err[EW-1] ? (EW+1)'(-{phase_err[EW-1], phase_err}) : (EW+1)'({1'b0, phase_err});

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (nco_word == '0 && !track_mode)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> ($stable(nco_word) && $stable(track_mode))); // R2

    AST_CAPTURE_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_mode && err_vld && fe_abs <= {1'b0, capture_lim}) |=> track_mode); // R5

    AST_CAPTURE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!track_mode && err_vld && fe_abs > {1'b0, capture_lim}) |=> !track_mode); // R5

    AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (track_mode && err_vld && pe_abs <= {1'b0, slip_lim}) |=> track_mode); // R6
endmodule

bind fpll_loop_filter fpll_loop_filter_chk #(.EW(EW), .AW(AW), .SHW(SHW), .CNTW(CNTW)) u_chk (.*);

// File: tb/fpll_loop_filter_bench.sv
module fpll_loop_filter_bench;
    localparam int EW = 16, AW = 32, SHW = 5, CNTW = 8;
    localparam longint MAXL = 64'sd2147483647;
    localparam longint MINL = -64'sd2147483648;

    logic clk = 1'b0, rst_n = 1'b0, err_vld = 1'b0;
    logic signed [EW-1:0] phase_err = '0, freq_err = '0;
    logic [EW-1:0] capture_lim = 16'd200, slip_lim = 16'd1000;
    logic [CNTW-1:0] slip_len = 8'd3;
    logic [SHW-1:0] fll_kp_sh = 5'd2, fll_ki_sh = 5'd6;
    logic [SHW-1:0] pll_a_sh = 5'd1, pll_b_sh = 5'd4, pll_c_sh = 5'd8;
    logic signed [AW-1:0] nco_word;
    logic track_mode;

    always #10 clk = ~clk;

    fpll_loop_filter #(.EW(EW), .AW(AW), .SHW(SHW), .CNTW(CNTW)) u_fpll_loop_filter (.*);

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        longint word;
        bit     mode;
        string  tag;
    } exp_t;
    exp_t sq[$];

    longint m_acc1 = 0, m_acc2 = 0, m_fint = 0, m_word = 0;
    bit     m_mode = 0;
    int     m_cnt = 0;

    function automatic longint clampl(input longint v);
        if (v > MAXL) return MAXL;
        if (v < MINL) return MINL;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input longint p, input longint f, input string tag);
        longint pa, fa;
        int lim;
        pa = (p < 0) ? -p : p;
        fa = (f < 0) ? -f : f;
        m_acc2 = clampl(m_acc2 + (p >>> pll_c_sh));
        m_acc1 = clampl(m_acc1 + (p >>> pll_b_sh) + m_acc2);
        if (!m_mode) begin
            m_fint = clampl(m_fint + (f >>> fll_ki_sh));
            m_word = clampl((p >>> pll_a_sh) + m_acc1 + (f >>> fll_kp_sh) + m_fint);
            if (fa <= longint'(capture_lim)) begin
                m_acc1 = clampl(m_acc1 + m_fint);
                m_fint = 0;
                m_mode = 1;
                m_cnt  = 0;
            end
        end else begin
            m_word = clampl((p >>> pll_a_sh) + m_acc1);
            lim = (slip_len == 0) ? 1 : int'(slip_len);
            if (pa > longint'(slip_lim)) begin
                m_cnt++;
                if (m_cnt >= lim) begin
                    m_mode = 0;
                    m_cnt  = 0;
                    m_fint = 0;
                end
            end else begin
                m_cnt = 0;
            end
        end
        sq.push_back('{word: m_word, mode: m_mode, tag: tag});
    endtask

    task automatic upd(input int p, input int f, input string tag);
        @(negedge clk);
        phase_err = EW'(p);
        freq_err  = EW'(f);
        err_vld   = 1'b1;
        model_step(longint'(phase_err), longint'(freq_err), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            err_vld   = 1'b0;
            phase_err = EW'(16'h7ABC ^ (i * 977));
            freq_err  = EW'(16'h8123 + i * 311);
        end
    endtask

    // monitor: compares one expected item per accepted update
    bit seen = 0;
    always @(posedge clk) seen <= err_vld && rst_n;
    always @(negedge clk) begin
        if (seen) begin
            if (sq.size() == 0) begin
                check("scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = sq.pop_front();
                check({e.tag, " word"}, longint'(nco_word), e.word);
                check({e.tag, " mode"}, longint'(track_mode), longint'(e.mode));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", longint'(nco_word), 0);
        check("R1 reset mode", longint'(track_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release word", longint'(nco_word), 0);

        // R3 / R9 acquisition with positive, negative and full-scale errors
        upd(500, 3000, "R3 acq pos");
        upd(-700, -2500, "R9 acq neg shift");
        idle(2);
        upd(-32768, -32768, "R9 acq min");
        upd(32767, 5000, "R3 acq max");
        upd(123, -201, "R5 above capture limit");
        // R2 idle with junk inputs
        idle(5);
        check("R2 idle word", longint'(nco_word), m_word);
        check("R2 idle mode", longint'(track_mode), 0);

        // R5 exact capture limit switches
        upd(50, -200, "R5 capture at limit");
        idle(1);
        check("R5 mode entered", longint'(track_mode), 1);

        // R4 tracking: freq_err must not matter; R8 handed-over offset present
        upd(100, 30000, "R4 trk fe ignored");
        upd(-300, -30000, "R4 trk fe ignored neg");
        upd(0, 12345, "R8 trk integrator kept");

        // R6 slip counting
        upd(2000, 0, "R6 slip one");
        upd(-2000, 0, "R6 slip two");
        upd(1000, 0, "R6 equal limit clears");
        upd(1500, 0, "R6 slip one again");
        upd(-1500, 0, "R6 slip two again");
        idle(3);
        check("R6 idle keeps lock", longint'(track_mode), 1);
        upd(1001, 0, "R6 slip three unlocks");
        idle(1);
        check("R6 back to acq", longint'(track_mode), 0);

        // R8 frequency integrator restarts, phase integrators kept
        upd(200, 3000, "R8 reacq first");
        upd(-50, 4000, "R8 reacq second");

        // R7 saturation: fast gains, full-scale phase error, stay in acquisition
        idle(1);
        pll_a_sh = 5'd0; pll_b_sh = 5'd0; pll_c_sh = 5'd0;
        for (int i = 0; i < 400; i++) upd(32767, 30000, "R7 drive to clamp");
        idle(2);
        check("R7 word clamped", longint'(nco_word), MAXL);
        upd(-32768, 30000, "R7 clamp no wrap");
        idle(2);
        check("R7 no sign flip", longint'(nco_word[AW-1]), 0);

        idle(3);
        check("scoreboard drained", longint'(sq.size()), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule